// File: doc/BRIEF.md
# Multiplexed line-interface I/O controller

This block steers a bank of 12 bidirectional pins and 4 chip-select pins that face up to four line-interface devices. A byte-wide register port lets a controller set per-pin directions, load the values each device should see, and read back what each device returned. The block has two modes.

In dynamic mode a scanner walks the chip-selects in turn. While one select is low, the shared pins present that device's data register on every pin set as an output. On the final clock of the slot, the pins set as inputs are stored into the same register. In static mode the scanner stops. The four chip-select pins become plain I/O: their directions come from data register 1 and their values from data register 2. The 12 shared pins are then driven from and sampled into data register 0 on every clock.

Top module: `sio_mux_ctrl`

## Requirements
- R1: While reset is applied, and at the first clock after it, every `io_oe` and `cs_oe` bit is 0 and `cs_out` is all ones. After reset every register reads 0, and the block is in dynamic mode.
- R2: Register map. Address 0h holds direction bits 7..0 and 1h holds bits 11..8. Device register n is at 2h+2n (bits 7..0) and 3h+2n (bits 11..8), for n = 0..3. Address Ch bit 0 is the mode bit (0 = dynamic, 1 = static). Bits 7..4 of a high-byte register read 0, and unmapped addresses read 0. A direction bit of 1 means output.
- R3: In dynamic mode, `cs_oe` is all ones and exactly one `cs_out` bit is low. The low bit advances 0,1,2,3,0 and stays on each device for SLOT_CYC clocks (default 16).
- R4: In dynamic mode, `io_oe` equals the direction register, and `io_out` equals device register n while `cs_out[n]` is low.
- R5: In dynamic mode, the clock edge that ends device n's slot loads `io_in` into the input-direction bits of device register n. Its output-direction bits are not changed.
- R6: If a register write lands on the same edge as a capture into that register, the input-direction bits take the pin value and the output-direction bits take the written value.
- R7: In static mode, `cs_oe` equals bits 3..0 of device register 1. `cs_out` shows bits 3..0 of device register 2, and those bits that are inputs take `cs_in` on every clock, so reads of register 2 return it. The scanner holds.
- R8: In static mode, `io_oe` equals the direction register and `io_out` equals device register 0. Every clock, the input-direction bits of register 0 take `io_in`, so a read one clock after a pin change returns the new value.
- R9: When the mode changes from static to dynamic, scanning restarts at device 0 with a full SLOT_CYC-clock slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| io_in | input | 12 | Shared pin input values |
| io_out | output | 12 | Shared pin output values |
| io_oe | output | 12 | Shared pin output enables (1 = drive) |
| cs_in | input | 4 | Chip-select pin input values (used in static mode) |
| cs_out | output | 4 | Chip-select pin outputs, active low in dynamic mode |
| cs_oe | output | 4 | Chip-select pin output enables |

## Verification
Two functions can land on the same clock edge: a software write to a device register, and the end-of-slot capture into that same register. The bench follows the chip-selects, counts the clocks of each slot, and raises a write to device 1's low byte exactly in that slot's final clock. The written byte and the device model's pattern differ on both the input and the output nibbles. The read-back is then judged bit by bit against the direction mask: pin values on input bits, written values on output bits.

// File: rtl/sio_pkg.sv
// Shared constants for the multiplexed line-interface I/O controller.
// Assumes a 4-bit register address space with the device registers packed
// from address 2h upward in low/high byte pairs.
package sio_pkg;
    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] A_DIR_LO    = 4'h0;
    localparam logic [ADDR_W-1:0] A_DIR_HI    = 4'h1;
    localparam logic [ADDR_W-1:0] A_DEV_BASE  = 4'h2;
    localparam logic [ADDR_W-1:0] A_MODE      = 4'hC;
endpackage

// File: rtl/sio_regs.sv
// Register file: direction, mode bit and one data register per device.
// Each device register is merged from a software write and a pin capture,
// and the capture wins on its masked bits. Assumes 9 <= NPIN <= 16 and
// NDEV <= 5, so that the map fits below the mode address.
module sio_regs
    import sio_pkg::*;
#(
    parameter int NPIN = 12,
    parameter int NDEV = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [7:0]                  wdata,
    output logic [7:0]                  rdata,
    input  logic [NDEV-1:0][NPIN-1:0]   cap_mask,
    input  logic [NDEV-1:0][NPIN-1:0]   cap_val,
    output logic [NPIN-1:0]             dir,
    output logic [NDEV-1:0][NPIN-1:0]   data,
    output logic                        static_mode
);
    localparam int HIW = NPIN - 8;

    // Direction register and mode bit, written byte-wise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir         <= '0;
            static_mode <= 1'b0;
        end else if (we) begin
            if (addr == A_DIR_LO) dir[7:0]      <= wdata;
            if (addr == A_DIR_HI) dir[NPIN-1:8] <= wdata[HIW-1:0];
            if (addr == A_MODE)   static_mode   <= wdata[0];
        end
    end

    for (genvar n = 0; n < NDEV; n++) begin : g_dev
        localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(A_DEV_BASE + 2*n);
        localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(A_DEV_BASE + 2*n + 1);
        logic [NPIN-1:0] nxt;
        logic [NPIN-1:0] q;

        // Software write view of this device register.
        always_comb begin
            nxt = q;
            if (we && addr == LO_A) nxt[7:0]      = wdata;
            if (we && addr == HI_A) nxt[NPIN-1:8] = wdata[HIW-1:0];
        end

        // Capture overrides the write on its masked bits.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= (nxt & ~cap_mask[n]) | (cap_val[n] & cap_mask[n]);
        end

        assign data[n] = q;
    end

    // Read multiplexer; unused high-nibble bits and holes read 0.
    always_comb begin
        rdata = '0;
        case (addr)
            A_DIR_LO: rdata = dir[7:0];
            A_DIR_HI: rdata = 8'(dir[NPIN-1:8]);
            A_MODE:   rdata = {7'd0, static_mode};
            default: begin
                for (int n = 0; n < NDEV; n++) begin
                    if (addr == ADDR_W'(A_DEV_BASE + 2*n))     rdata = data[n][7:0];
                    if (addr == ADDR_W'(A_DEV_BASE + 2*n + 1)) rdata = 8'(data[n][NPIN-1:8]);
                end
            end
        endcase
    end
endmodule

// File: rtl/sio_scan.sv
// Round-robin slot scanner. Holds each device for SLOT_CYC clocks and flags
// the final clock of a slot. Returns to device 0, count 0, whenever run is low.
module sio_scan #(
    parameter int NDEV     = 4,
    parameter int SLOT_CYC = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run,
    output logic [$clog2(NDEV)-1:0]   slot,
    output logic                      last
);
    localparam int SW = $clog2(NDEV);
    localparam int CW = $clog2(SLOT_CYC);

    logic [CW-1:0] cnt;

    // Final clock of the current slot.
    assign last = run && (cnt == CW'(SLOT_CYC - 1));

    // Advance the dwell counter and the slot index.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt  <= '0;
            slot <= '0;
        end else if (last) begin
            cnt  <= '0;
            slot <= (slot == SW'(NDEV - 1)) ? '0 : slot + 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sio_pads.sv
// Pad steering and capture selection for both modes. Combinational.
// Assumes NDEV >= 3, because static mode borrows device registers 1 and 2
// for the chip-select pins.
module sio_pads #(
    parameter int NPIN = 12,
    parameter int NDEV = 4
) (
    input  logic                        live,
    input  logic                        static_mode,
    input  logic                        scan_last,
    input  logic [$clog2(NDEV)-1:0]     slot,
    input  logic [NPIN-1:0]             dir,
    input  logic [NDEV-1:0][NPIN-1:0]   data,
    input  logic [NPIN-1:0]             io_in,
    input  logic [NDEV-1:0]             cs_in,
    output logic [NPIN-1:0]             io_out,
    output logic [NPIN-1:0]             io_oe,
    output logic [NDEV-1:0]             cs_out,
    output logic [NDEV-1:0]             cs_oe,
    output logic [NDEV-1:0][NPIN-1:0]   cap_mask,
    output logic [NDEV-1:0][NPIN-1:0]   cap_val
);
    // Route pins and pick which register bits are loaded this clock.
    always_comb begin
        io_oe    = dir;
        cap_mask = '0;
        for (int n = 0; n < NDEV; n++) cap_val[n] = io_in;
        if (static_mode) begin
            io_out = data[0];
            cs_oe  = live ? data[1][NDEV-1:0] : '0;
            cs_out = data[2][NDEV-1:0];
            if (live) begin
                cap_mask[0] = ~dir;
                cap_mask[2] = NPIN'(~data[1][NDEV-1:0]);
                cap_val[2]  = NPIN'(cs_in);
            end
        end else begin
            io_out = data[slot];
            cs_oe  = live ? '1 : '0;
            cs_out = live ? ~(NDEV'(1) << slot) : '1;
            if (scan_last) cap_mask[slot] = ~dir;
        end
    end
endmodule

// File: rtl/sio_mux_ctrl.sv
// Top of the multiplexed line-interface I/O controller. Ties the register
// file, the slot scanner and the pad steering together. A one-flop flag keeps
// the chip-selects released until the first clock after reset.
module sio_mux_ctrl
    import sio_pkg::*;
#(
    parameter int NPIN     = 12,
    parameter int NDEV     = 4,
    parameter int SLOT_CYC = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    input  logic [NPIN-1:0]      io_in,
    output logic [NPIN-1:0]      io_out,
    output logic [NPIN-1:0]      io_oe,
    input  logic [NDEV-1:0]      cs_in,
    output logic [NDEV-1:0]      cs_out,
    output logic [NDEV-1:0]      cs_oe
);
    localparam int SW = $clog2(NDEV);

    logic                       live;
    logic                       static_mode;
    logic                       scan_last;
    logic [SW-1:0]              slot;
    logic [NPIN-1:0]            dir_q;
    logic [NDEV-1:0][NPIN-1:0]  data_q;
    logic [NDEV-1:0][NPIN-1:0]  cap_mask;
    logic [NDEV-1:0][NPIN-1:0]  cap_val;

    // Goes high one clock after reset is released.
    always_ff @(posedge clk) begin
        live <= rst_n;
    end

    sio_regs #(.NPIN(NPIN), .NDEV(NDEV)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .cap_mask(cap_mask),
        .cap_val(cap_val), .dir(dir_q), .data(data_q),
        .static_mode(static_mode)
    );

    sio_scan #(.NDEV(NDEV), .SLOT_CYC(SLOT_CYC)) u_scan (
        .clk(clk), .rst_n(rst_n), .run(live && !static_mode),
        .slot(slot), .last(scan_last)
    );

    sio_pads #(.NPIN(NPIN), .NDEV(NDEV)) u_pads (
        .live(live), .static_mode(static_mode), .scan_last(scan_last),
        .slot(slot), .dir(dir_q), .data(data_q), .io_in(io_in),
        .cs_in(cs_in), .io_out(io_out), .io_oe(io_oe), .cs_out(cs_out),
        .cs_oe(cs_oe), .cap_mask(cap_mask), .cap_val(cap_val)
    );
endmodule

// File: rtl/sio_mux_chk.sv
// Property checker for sio_mux_ctrl, attached by bind. Watches the pads and
// the register state to check the reset release, the scan order and the
// static-mode routing and sampling.
module sio_mux_chk #(
    parameter int NPIN = 12,
    parameter int NDEV = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             live,
    input logic             static_mode,
    input logic [NPIN-1:0]  dir,
    input logic [NPIN-1:0]  data0,
    input logic [NDEV-1:0]  data1_lo,
    input logic [NPIN-1:0]  io_in,
    input logic [NPIN-1:0]  io_oe,
    input logic [NDEV-1:0]  cs_out,
    input logic [NDEV-1:0]  cs_oe
);
    logic [NDEV-1:0] sel;
    assign sel = ~cs_out;

    // R1: pins are released at the first clock after reset.
    assert_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (io_oe == '0 && cs_oe == '0 && cs_out == '1));

    // R3: exactly one select is driven low in dynamic mode.
    assert_cs_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !static_mode) |-> (cs_oe == '1 && $countones(sel) == 1));

    // R3: a select change is a step to the next device.
    assert_cs_rotate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !static_mode && $past(live) && !$past(static_mode) && !$stable(sel))
        |-> (sel == {$past(sel[NDEV-2:0]), $past(sel[NDEV-1])}));

    // R4: shared pin directions follow the direction register.
    assert_dir_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !static_mode |-> (io_oe == dir));

    // R7: chip-select enables come from device register 1 in static mode.
    assert_cs_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (live && static_mode) |-> (cs_oe == data1_lo));

    // R8: input bits of register 0 hold last clock's pin values.
    assert_static_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(live) && $past(static_mode))
        |-> (((data0 ^ $past(io_in)) & ~$past(dir)) == '0));
endmodule

bind sio_mux_ctrl sio_mux_chk #(.NPIN(NPIN), .NDEV(NDEV)) u_chk (
    .clk(clk), .rst_n(rst_n), .live(live), .static_mode(static_mode),
    .dir(dir_q), .data0(data_q[0]), .data1_lo(data_q[1][NDEV-1:0]),
    .io_in(io_in), .io_oe(io_oe), .cs_out(cs_out), .cs_oe(cs_oe)
);

// File: tb/tb_sio_mux_ctrl.sv
// Self-checking bench for sio_mux_ctrl. A device model answers each select
// with its own pattern. A tracker follows the selects and the dwell, and the
// main thread sweeps directions and patterns in both modes.
module tb_sio_mux_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int SLOT = 16;
    localparam int ROUND = 4 * SLOT;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [11:0] io_in, io_out, io_oe;
    logic [3:0]  cs_in = '0;
    logic [3:0]  cs_out, cs_oe;

    logic        model_on = 1'b0;
    logic [11:0] io_force = '0;
    logic [11:0] pat [4];
    logic [11:0] wval [4];
    logic [11:0] exp_d [4];
    logic [11:0] cur_dir = '0;
    logic        trk_on = 1'b0;
    int          n_chk = 0;
    int          n_fail = 0;
    int          dwell = 0;
    logic [3:0]  prev_cs = 4'hF;

    sio_mux_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .io_in(io_in),
        .io_out(io_out), .io_oe(io_oe), .cs_in(cs_in), .cs_out(cs_out),
        .cs_oe(cs_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int dev_of(input logic [3:0] c);
        for (int i = 0; i < 4; i++) if (!c[i]) return i;
        return 0;
    endfunction

    // Device model: the selected device drives its own pattern.
    assign io_in = model_on ? pat[dev_of(cs_out)] : io_force;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wr12(input logic [3:0] a, input logic [11:0] v);
        wr(a, v[7:0]);
        wr(a + 4'd1, {4'h0, v[11:8]});
    endtask

    // Tracker: follows the selects just after each edge.
    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            dwell = 0; prev_cs = 4'hF;
        end else begin
            if (cs_out != prev_cs) begin
                if (trk_on && prev_cs != 4'hF) begin
                    chk(dwell == SLOT - 1, "R3 dwell", dwell + 1, SLOT);
                    chk(dev_of(cs_out) == (dev_of(prev_cs) + 1) % 4, "R3 order",
                        dev_of(cs_out), (dev_of(prev_cs) + 1) % 4);
                end
                dwell = 0;
            end else begin
                dwell++;
            end
            prev_cs = cs_out;
            if (trk_on) begin
                chk($countones(~cs_out) == 1 && cs_oe == 4'hF, "R3 select",
                    {cs_oe, cs_out}, 8'hF0);
                chk(io_out == exp_d[dev_of(cs_out)], "R4 io_out",
                    io_out, exp_d[dev_of(cs_out)]);
                chk(io_oe == cur_dir, "R4 io_oe", io_oe, cur_dir);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic [11:0] dirs [4];
        dirs[0] = 12'hFF0; dirs[1] = 12'h0F3; dirs[2] = 12'hA5A; dirs[3] = 12'h000;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(io_oe == 0 && cs_oe == 0 && cs_out == 4'hF, "R1 reset pins",
            {io_oe, cs_oe, cs_out}, 20'h0000F);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_oe == 4'hF && cs_out == 4'hE, "R1 scan start", {cs_oe, cs_out}, 8'hFE);
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), d);
            chk(d == 0, "R1 reset registers", d, 0);
        end

        // R2: map and upper nibble
        wr(4'h1, 8'hFF);
        rd(4'h1, d);
        chk(d == 8'h0F, "R2 high nibble", d, 8'h0F);
        wr(4'h0, 8'h5A);
        rd(4'h0, d);
        chk(d == 8'h5A, "R2 dir low", d, 8'h5A);
        rd(4'hA, d);
        chk(d == 0, "R2 hole", d, 0);

        // R4, R5: dynamic sweeps over directions and patterns
        for (int k = 0; k < 4; k++) begin
            trk_on = 1'b0;
            cur_dir = dirs[k];
            for (int n = 0; n < 4; n++) begin
                pat[n]  = 12'((n + 1) * 12'h321 + k * 12'h1B7);
                wval[n] = 12'(((n + 3) * 12'h2C5) ^ (k * 12'h0F1));
            end
            model_on = 1'b1;
            wr12(4'h0, cur_dir);
            for (int n = 0; n < 4; n++) begin
                wr12(4'(2 + 2 * n), wval[n]);
                exp_d[n] = (wval[n] & cur_dir) | (pat[n] & ~cur_dir);
            end
            repeat (2 * ROUND) @(negedge clk);
            trk_on = 1'b1;
            repeat (2 * ROUND) @(negedge clk);
            trk_on = 1'b0;
            for (int n = 0; n < 4; n++) begin
                rd(4'(2 + 2 * n), d);
                chk(d == exp_d[n][7:0], "R5 capture low", d, exp_d[n][7:0]);
                rd(4'(3 + 2 * n), d);
                chk(d == {4'h0, exp_d[n][11:8]}, "R5 capture high", d, exp_d[n][11:8]);
            end
        end

        // R6: write in the capture clock of device 1
        wr12(4'h0, 12'h0F0);
        repeat (ROUND) @(negedge clk);
        do @(negedge clk); while (!(dev_of(cs_out) == 1 && dwell == SLOT - 1));
        reg_we = 1'b1; reg_addr = 4'h4; reg_wdata = 8'h3C;
        @(negedge clk);
        reg_we = 1'b0;
        rd(4'h4, d);
        chk(d == ((8'h3C & 8'hF0) | (pat[1][7:0] & 8'h0F)), "R6 collision", d,
            (8'h3C & 8'hF0) | (pat[1][7:0] & 8'h0F));

        // R7: static mode, exhaustive chip-select directions
        model_on = 1'b0;
        wr(4'hC, 8'h01);
        rd(4'hC, d);
        chk(d == 8'h01, "R2 mode readback", d, 1);
        for (int m = 0; m < 16; m++) begin
            logic [3:0] d1, wc, ci;
            d1 = 4'(m);
            wc = 4'(m * 7 + 3);
            ci = 4'(m * 5 + 9);
            cs_in = ci;
            wr(4'h4, {4'h0, d1});
            wr(4'h6, {4'h0, wc});
            @(negedge clk);
            chk(cs_oe == d1, "R7 cs_oe", cs_oe, d1);
            chk((cs_out & d1) == (wc & d1), "R7 cs_out", cs_out & d1, wc & d1);
            rd(4'h6, d);
            chk(d[3:0] == ((wc & d1) | (ci & ~d1)), "R7 cs readback", d[3:0],
                (wc & d1) | (ci & ~d1));
        end

        // R8: static mode on the shared pins
        for (int k = 0; k < 4; k++) begin
            logic [11:0] w0, e0;
            cur_dir  = dirs[k] ^ 12'h3C5;
            w0       = 12'(12'hABC + k * 12'h111);
            io_force = 12'(12'h5A3 ^ (k * 12'h249));
            wr12(4'h0, cur_dir);
            wr12(4'h2, w0);
            @(negedge clk);
            e0 = (w0 & cur_dir) | (io_force & ~cur_dir);
            chk(io_oe == cur_dir, "R8 io_oe", io_oe, cur_dir);
            chk(io_out == e0, "R8 io_out", io_out, e0);
            @(negedge clk);
            io_force = ~io_force;
            rd(4'h2, d);
            e0 = (w0 & cur_dir) | (io_force & ~cur_dir);
            chk(d == e0[7:0], "R8 follow low", d, e0[7:0]);
            rd(4'h3, d);
            chk(d == {4'h0, e0[11:8]}, "R8 follow high", d, e0[11:8]);
        end

        // R9: back to dynamic restarts at device 0
        wr(4'hC, 8'h00);
        for (int c = 0; c < SLOT; c++) begin
            chk(cs_out == 4'hE && cs_oe == 4'hF, "R9 restart slot", cs_out, 4'hE);
            @(negedge clk);
        end
        chk(cs_out == 4'hD, "R9 next device", cs_out, 4'hD);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule